// File: doc/BRIEF.md
# Two-of-Four Sparse Dot-Product Engine

This block computes a signed dot product between a weight vector in which every group of four consecutive weights holds exactly two non-zero entries and a dense activation vector. The weights reach the block already compressed. Each beat carries the two kept weights of one group, a 2-bit position for each of them, and the four dense activations of the same group. Zero weights are never delivered and never multiplied.

On every valid beat the engine decodes the two positions to pick the matching activations. It forms two signed products and adds their sign-extended sum to a running accumulator. A group of four therefore costs two multiply-accumulates instead of four. A last flag on a beat closes the current dot product. The finished sum appears on a registered output together with a one-cycle valid strobe, and the next valid beat starts a fresh sum from zero.

A group whose two positions are equal breaks the two-of-four rule. Such a group is reported through a one-cycle error flag and adds nothing to the sum. The accumulator is sized from a maximum group count, so a dot product of up to that many groups cannot overflow.

Top module: `sparse24_dot`

## Requirements
- R1: During reset and on the first cycle after it, `res_valid` and `meta_err` are 0 and `res_data` is 0.
- R2: A position value p (0 to 3) selects the activation in bits [p*DATA_W +: DATA_W] of `act_vec`. Position 0 is the least significant lane.
- R3: Weights and activations are two's complement. Each product is exact and sign-extended before it is added, so negative and full-scale values give the exact signed sum.
- R4: A dot product is the sum of w0*act[pos0] + w1*act[pos1] over every valid beat from the first beat after the previous last beat, up to and including the beat that has `in_last` high.
- R5: `res_valid` goes high for exactly one cycle, on the cycle after the edge that accepts the last beat. `res_data` carries the sum in that cycle and holds it until the next result.
- R6: The accumulator starts from zero for every new dot product, including one whose first beat comes right after a last beat, so earlier sums never leak in.
- R7: A cycle with `in_valid` low has no effect on the sum, on `res_valid` or on `meta_err`, whatever the other inputs hold, `in_last` included.
- R8: A valid beat with `pos0 == pos1` raises `meta_err` for one cycle, on the cycle after it is accepted, and adds zero to the sum. The dot product still continues or closes as normal.
- R9: With MAX_GROUPS = 64 and DATA_W = 8, a dot product of 64 groups of extreme operands gives the exact sum with no wrap. Examples: all -128*-128 gives 2097152, and all 127*-128 gives -2080768.
- R10: A dot product of a single beat, with `in_last` high on its first beat, gives that group's two-product sum. Such single-beat dot products can follow one another on every cycle, and each gives its own result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat present this cycle |
| in_last | input | 1 | Beat closes the current dot product |
| wt0 | input | DATA_W | First kept weight, signed |
| wt1 | input | DATA_W | Second kept weight, signed |
| pos0 | input | 2 | Lane of the activation matching `wt0` |
| pos1 | input | 2 | Lane of the activation matching `wt1` |
| act_vec | input | 4*DATA_W | Four dense activations of the group, signed |
| res_valid | output | 1 | One-cycle strobe for a finished dot product |
| res_data | output | ACC_W | Signed dot-product result |
| meta_err | output | 1 | One-cycle flag for a group with equal positions |

## Verification
The finished sum and the position error flag both come from one register stage. Each is therefore due in the cycle that follows the rising edge accepting the beat that causes it. The monitor samples a quarter period after every rising edge. It compares `meta_err` with the inputs seen at that same edge, and it pops an expected sum from the scoreboard queue only when `res_valid` is high. A strobe with nothing queued, a missing strobe at the end of the run, or a change in `res_data` between strobes each counts as a failure. These rules hold the engine to the one-cycle latency and the one-cycle pulse width.

// File: rtl/sp24_pkg.sv
package sp24_pkg;
  // number of weights per compressed group and kept entries per group
  localparam int LANES = 4;
  localparam int KEEP  = 2;
  localparam int IDX_W = $clog2(LANES);

  typedef logic [IDX_W-1:0] lane_idx_t;
endpackage

// File: rtl/sp24_gather.sv
// Steers the two activations named by the position metadata.
module sp24_gather
  import sp24_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [LANES*DATA_W-1:0] act_vec,
  input  lane_idx_t               sel0,
  input  lane_idx_t               sel1,
  output logic signed [DATA_W-1:0] pick0,
  output logic signed [DATA_W-1:0] pick1,
  output logic                    dup
);
  logic signed [DATA_W-1:0] lane [LANES];
  logic [LANES-1:0] hit0;
  logic [LANES-1:0] hit1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = act_vec[g*DATA_W +: DATA_W];
    assign hit0[g] = (sel0 == IDX_W'(g));
    assign hit1[g] = (sel1 == IDX_W'(g));
  end

  // AND-OR selection: one level of gating plus an OR tree per bit
  always_comb begin
    pick0 = '0;
    pick1 = '0;
    for (int i = 0; i < LANES; i++) begin
      pick0 = pick0 | (hit0[i] ? lane[i] : '0);
      pick1 = pick1 | (hit1[i] ? lane[i] : '0);
    end
  end

  assign dup = |(hit0 & hit1);
endmodule

// File: rtl/sp24_mac_pair.sv
// Two signed multiplies and their sign-extended sum; a killed group yields zero.
module sp24_mac_pair #(
  parameter int DATA_W = 8,
  localparam int PROD_W = 2 * DATA_W,
  localparam int SUM_W  = PROD_W + 1
) (
  input  logic signed [DATA_W-1:0] wa,
  input  logic signed [DATA_W-1:0] wb,
  input  logic signed [DATA_W-1:0] xa,
  input  logic signed [DATA_W-1:0] xb,
  input  logic                     kill,
  output logic signed [SUM_W-1:0]  pair_sum
);
  logic signed [PROD_W-1:0] prod_a;
  logic signed [PROD_W-1:0] prod_b;

  assign prod_a = wa * xa;
  assign prod_b = wb * xb;

  always_comb begin
    if (kill) pair_sum = '0;
    else      pair_sum = {prod_a[PROD_W-1], prod_a} + {prod_b[PROD_W-1], prod_b};
  end
endmodule

// File: rtl/sp24_accum.sv
// Running sum per dot product with registered result and strobe.
module sp24_accum #(
  parameter int SUM_W      = 17,
  parameter int ACC_W      = 24,
  parameter int MAX_GROUPS = 64,
  localparam int CNT_W     = $clog2(MAX_GROUPS + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    beat_ok,
  input  logic                    beat_last,
  input  logic                    beat_err,
  input  logic signed [SUM_W-1:0] contrib,
  output logic signed [ACC_W-1:0] res_q,
  output logic                    res_valid_q
);
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] base;
  logic signed [ACC_W-1:0] contrib_ext;
  logic signed [ACC_W-1:0] next_sum;
  logic                    fresh_q;

  // a new dot product starts from zero without spending a clear cycle
  assign base        = fresh_q ? '0 : acc_q;
  assign contrib_ext = {{(ACC_W-SUM_W){contrib[SUM_W-1]}}, contrib};
  assign next_sum    = base + contrib_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q       <= '0;
      fresh_q     <= 1'b1;
      res_q       <= '0;
      res_valid_q <= 1'b0;
    end else begin
      res_valid_q <= beat_ok && beat_last;
      if (beat_ok) begin
        acc_q   <= next_sum;
        fresh_q <= beat_last;
        if (beat_last) res_q <= next_sum;
      end
    end
  end

  // ---- checking logic: group count and a one-bit-wider sum ----
  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    cnt_next;
  logic signed [ACC_W:0] wide_sum;

  assign cnt_next = fresh_q ? CNT_W'(1)
                  : ((cnt_q > CNT_W'(MAX_GROUPS)) ? cnt_q : cnt_q + CNT_W'(1));
  assign wide_sum = {base[ACC_W-1], base} + {contrib_ext[ACC_W-1], contrib_ext};

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (beat_ok) cnt_q <= beat_last ? '0 : cnt_next;
  end

  // R1
  rst_state_chk: assert property (@(posedge clk) rst |=> (!res_valid_q && res_q == '0));

  // R5
  res_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid_q |-> $past(beat_ok && beat_last));

  // R5
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(beat_ok && beat_last) |=> $stable(res_q));

  // R8
  err_no_add_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_ok && beat_err) |=> (acc_q == $past(base)));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_ok && cnt_next <= CNT_W'(MAX_GROUPS)) |-> (wide_sum[ACC_W] == wide_sum[ACC_W-1]));
endmodule

// File: rtl/sparse24_dot.sv
// Two-of-four compressed-weight dot-product engine.
module sparse24_dot
  import sp24_pkg::*;
#(
  parameter int  DATA_W     = 8,
  parameter int  MAX_GROUPS = 64,
  localparam int ACC_W      = 2 * DATA_W + $clog2(KEEP * MAX_GROUPS) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_last,
  input  logic [DATA_W-1:0]       wt0,
  input  logic [DATA_W-1:0]       wt1,
  input  logic [IDX_W-1:0]        pos0,
  input  logic [IDX_W-1:0]        pos1,
  input  logic [LANES*DATA_W-1:0] act_vec,
  output logic                    res_valid,
  output logic [ACC_W-1:0]        res_data,
  output logic                    meta_err
);
  localparam int SUM_W = 2 * DATA_W + 1;

  logic signed [DATA_W-1:0] pick0;
  logic signed [DATA_W-1:0] pick1;
  logic                     dup;
  logic signed [SUM_W-1:0]  pair_sum;
  logic signed [ACC_W-1:0]  res_q;
  logic                     meta_err_q;

  sp24_gather #(.DATA_W(DATA_W)) u_gather (
    .act_vec (act_vec),
    .sel0    (pos0),
    .sel1    (pos1),
    .pick0   (pick0),
    .pick1   (pick1),
    .dup     (dup)
  );

  sp24_mac_pair #(.DATA_W(DATA_W)) u_mac (
    .wa       ($signed(wt0)),
    .wb       ($signed(wt1)),
    .xa       (pick0),
    .xb       (pick1),
    .kill     (dup),
    .pair_sum (pair_sum)
  );

  sp24_accum #(
    .SUM_W      (SUM_W),
    .ACC_W      (ACC_W),
    .MAX_GROUPS (MAX_GROUPS)
  ) u_accum (
    .clk         (clk),
    .rst         (rst),
    .beat_ok     (in_valid),
    .beat_last   (in_last),
    .beat_err    (dup),
    .contrib     (pair_sum),
    .res_q       (res_q),
    .res_valid_q (res_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) meta_err_q <= 1'b0;
    else     meta_err_q <= in_valid && dup;
  end

  assign res_data = res_q;
  assign meta_err = meta_err_q;

  // R8
  meta_flag_chk: assert property (@(posedge clk) disable iff (rst)
    meta_err |-> $past(in_valid && (pos0 == pos1)));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && !meta_err));
endmodule

// File: tb/sparse24_dot_test.sv
module sparse24_dot_test;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int K  = 64;
  localparam int AW = 2 * W + $clog2(2 * K) + 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic            in_last = 1'b0;
  logic [W-1:0]    wt0 = '0;
  logic [W-1:0]    wt1 = '0;
  logic [1:0]      pos0 = '0;
  logic [1:0]      pos1 = '0;
  logic [4*W-1:0]  act_vec = '0;
  logic            res_valid;
  logic [AW-1:0]   res_data;
  logic            meta_err;

  sparse24_dot #(.DATA_W(W), .MAX_GROUPS(K)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
    .wt0(wt0), .wt1(wt1), .pos0(pos0), .pos1(pos1), .act_vec(act_vec),
    .res_valid(res_valid), .res_data(res_data), .meta_err(meta_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int      checks = 0;
  int      fails  = 0;
  bit      mon_on = 0;
  bit      finished = 0;
  longint  exp_q[$];
  longint  run_sum = 0;
  longint  last_res = 0;
  string   cur_req = "R4";

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic longint lane_val(input logic [4*W-1:0] av, input logic [1:0] p);
    return longint'($signed(av[p*W +: W]));
  endfunction

  // driver: one valid beat; expected sum pushed when the beat closes
  task automatic beat(input int w0, input int w1, input logic [1:0] p0, input logic [1:0] p1,
                      input logic [4*W-1:0] av, input bit last);
    @(negedge clk);
    in_valid = 1'b1; in_last = last;
    wt0 = W'(w0); wt1 = W'(w1); pos0 = p0; pos1 = p1; act_vec = av;
    if (p0 != p1)
      run_sum += longint'(w0) * lane_val(av, p0) + longint'(w1) * lane_val(av, p1);
    if (last) begin
      exp_q.push_back(run_sum);
      run_sum = 0;
    end
  endtask

  // idle cycles with junk on every other input (R7)
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b1;
      wt0 = W'($urandom); wt1 = W'($urandom);
      pos0 = 2'($urandom); pos1 = pos0;
      act_vec = {$urandom};
    end
  endtask

  function automatic logic [4*W-1:0] pack4(input int a0, input int a1, input int a2, input int a3);
    return {W'(a3), W'(a2), W'(a1), W'(a0)};
  endfunction

  // monitor: samples a quarter period after each rising edge
  initial begin
    bit pend_meta;
    forever begin
      @(posedge clk);
      pend_meta = !rst && in_valid && (pos0 == pos1);
      #(CLK_PERIOD/4);
      if (mon_on) begin
        check(meta_err == pend_meta, "R8 meta_err", longint'(meta_err), longint'(pend_meta));
        if (res_valid) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected res_valid", 1, 0);
          end else begin
            longint e;
            e = exp_q.pop_front();
            check(longint'($signed(res_data)) == e, cur_req, longint'($signed(res_data)), e);
          end
          last_res = longint'($signed(res_data));
        end else begin
          check(longint'($signed(res_data)) == last_res, "R5 hold",
                longint'($signed(res_data)), last_res);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "watchdog expired", 0, 1);
    wrap_up();
  end

  initial begin
    logic [4*W-1:0] av;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(res_valid == 1'b0 && meta_err == 1'b0 && res_data == '0, "R1 in reset",
          longint'(res_data), 0);
    rst = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0 && meta_err == 1'b0 && res_data == '0, "R1 after reset",
          longint'(res_data), 0);
    mon_on = 1;

    // R2 / R10: every distinct position pair, single-beat dot products back to back
    cur_req = "R2 lane select";
    av = pack4(3, -5, 7, -11);
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        if (a != b) beat(1, 100, 2'(a), 2'(b), av, 1'b1);
    idle(2);

    // R3: signed extremes
    cur_req = "R3 signed";
    beat(-128, 127, 2'd0, 2'd3, pack4(-128, 0, 0, -128), 1'b1);
    beat(-1, -128, 2'd1, 2'd2, pack4(0, -128, 127, 0), 1'b1);
    idle(2);

    // R4: multi-beat sums with mixed values
    cur_req = "R4 multi-beat";
    for (int n = 0; n < 6; n++)
      beat($signed(8'($urandom)), $signed(8'($urandom)), 2'(n % 4), 2'((n + 1) % 4),
           {$urandom}, n == 5);
    idle(1);

    // R7: gaps with junk inside a dot product
    cur_req = "R7 gaps ignored";
    beat(5, -6, 2'd2, 2'd0, pack4(9, 1, -4, 2), 1'b0);
    idle(3);
    beat(-7, 8, 2'd3, 2'd1, pack4(1, 12, 3, -9), 1'b0);
    idle(2);
    beat(2, 2, 2'd0, 2'd2, pack4(20, 0, 30, 0), 1'b1);
    idle(2);

    // R8: equal positions contribute nothing
    cur_req = "R8 dup group";
    beat(10, 3, 2'd1, 2'd3, pack4(0, 4, 0, 5), 1'b0);
    beat(100, 100, 2'd2, 2'd2, pack4(50, 50, 50, 50), 1'b0);
    beat(1, 1, 2'd0, 2'd1, pack4(6, 7, 0, 0), 1'b1);
    beat(90, 90, 2'd3, 2'd3, pack4(9, 9, 9, 9), 1'b1);
    idle(2);

    // R9: full-length extreme dot products
    cur_req = "R9 no overflow";
    for (int n = 0; n < K; n++)
      beat(-128, -128, 2'd0, 2'd1, pack4(-128, -128, 0, 0), n == K - 1);
    for (int n = 0; n < K; n++)
      beat(127, 127, 2'd2, 2'd3, pack4(0, 0, -128, -128), n == K - 1);
    // R6: new sum starts right after a last beat
    cur_req = "R6 fresh start";
    beat(3, 4, 2'd0, 2'd3, pack4(2, 0, 0, 5), 1'b1);
    beat(-1, 1, 2'd1, 2'd2, pack4(0, 7, 9, 0), 1'b0);
    beat(2, 0, 2'd3, 2'd0, pack4(1, 0, 0, 6), 1'b1);
    idle(4);

    check(exp_q.size() == 0, "R5 missing results", longint'(exp_q.size()), 0);
    wrap_up();
  end
endmodule